// File: doc/BRIEF.md
# Compare-Triggered ADC Start Controller

This block pairs a free-running 16-bit timer with a 16-bit compare register and a 4-bit compare-mode field. When the mode field selects the special-event setting and the timer equals the compare value, a one-cycle event fires. The event always returns the timer to zero, so the interval between events repeats on its own without software. The same event may also launch an analog-to-digital conversion, but only when the converter is enabled and idle. Timer reset and conversion start are therefore gated separately.

The conversion itself is modelled by a fixed-length cycle count. While it runs, the start/busy bit in the control register reads 1. At the end the bit clears, a stub result derived from the selected channel is loaded, and an interrupt flag is raised. Software can also start a conversion by writing the start bit, abort one by clearing it, and clear the flag. All state is reached through a small byte-wide register port with a combinational read.

Top module: `cmp_adc_starter`

## Requirements
- R1: `cmpEvent` is high in a cycle exactly when the mode field (address 4, bits [3:0]) holds 4'b1011 and the timer equals the compare value.
- R2: Without an event or timer write, the timer increases by one per clock and wraps at 16 bits. A byte write to address 0 (low) or 1 (high) replaces that byte and takes priority over an event clear in the same cycle.
- R3: Every event clears the timer on the next clock, whatever the enable and busy state.
- R4: An event while enable is set and no conversion runs sets the start/busy bit on the next clock. This start takes effect even if a control-register write falls in the same cycle.
- R5: An event while enable is clear leaves the start/busy bit at 0 but still clears the timer.
- R6: A control write sets the start/busy bit only if enable was already 1 before that write. Setting enable and start in one write starts nothing.
- R7: A started conversion keeps the start/busy bit at 1 for exactly CONV_CYCLES clocks. It then clears, the result register (address 6) loads {chan, ~chan, 2'b10} from the current channel field, and the interrupt flag sets.
- R8: An event during a running conversion does not restart it. The conversion ends at its original time, and the event still clears the timer.
- R9: Writing 0 to the start/busy bit during a conversion, other than in its last cycle, ends it on the next clock. The interrupt flag does not set and the result does not change.
- R10: The control register (address 5) has clock select [7:6], channel [5:3], start/busy [2], bit 1 reading 0 and enable [0]. After reset it reads 0, as do the timer, compare, mode (upper four bits always 0) and flag.
- R11: The interrupt flag is bit 0 of address 7 (other bits read 0) and drives `adcIrq`. Writing 1 to it clears it, but a completion in the same cycle leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data at regAddr |
| cmpEvent | output | 1 | Special-event compare match pulse |
| adcIrq | output | 1 | Conversion-complete interrupt flag |

## Verification
A compare event and a software write to the control register can land in the same cycle. The bench provokes this by watching its own model's timer. It issues the write on the exact cycle the timer meets the compare value: once with enable already set and a start bit of 0 (the trigger must still start the conversion), and once with the write turning enable and start on together (nothing must start, but the timer must clear). A completion that coincides with a flag clear is staged the same way, and the result is judged by comparing every output and the addressed read value with the model on each clock.

// File: rtl/cmp_adc_pkg.sv
package cmp_adc_pkg;
  localparam int DATA_W = 8;
  localparam logic [3:0] SPECIAL_MODE = 4'b1011;
  localparam int GO_BIT = 2;
  localparam int EN_BIT = 0;

  typedef enum logic [2:0] {
    A_TMR_LO = 3'd0,
    A_TMR_HI = 3'd1,
    A_CMP_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_MODE   = 3'd4,
    A_CTRL   = 3'd5,
    A_RES    = 3'd6,
    A_FLAG   = 3'd7
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic finishConv;
  } convStrobe_t;

  function automatic logic [DATA_W-1:0] stubResult(input logic [2:0] ch);
    return {ch, ~ch, 2'b10};
  endfunction
endpackage

// File: rtl/cmp_adc_ctrl.sv
module cmp_adc_ctrl
  import cmp_adc_pkg::*;
#(
  parameter int CONV_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        matchHit,
  input  logic        enBit,
  input  logic        wrCtrl,
  input  logic        wrGoVal,
  input  logic        wrFlagClr,
  output convStrobe_t strobe,
  output logic        goBit,
  output logic        irqFlag
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] convCnt;
  logic lastCycle, trigStart, swStart, startConv, abortConv;

  always_comb begin
    lastCycle = goBit && (convCnt == LAST_CNT);
    trigStart = matchHit && enBit && !goBit;
    swStart   = wrCtrl && wrGoVal && enBit && !goBit;
    startConv = trigStart || swStart;
    abortConv = goBit && !lastCycle && wrCtrl && !wrGoVal;
    strobe.clrTimer   = matchHit;
    strobe.finishConv = lastCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goBit   <= 1'b0;
      convCnt <= '0;
    end else if (startConv) begin
      goBit   <= 1'b1;
      convCnt <= '0;
    end else if (lastCycle || abortConv) begin
      goBit   <= 1'b0;
      convCnt <= '0;
    end else if (goBit) begin
      convCnt <= convCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irqFlag <= 1'b0;
    else if (lastCycle)
      irqFlag <= 1'b1;
    else if (wrFlagClr)
      irqFlag <= 1'b0;
  end
endmodule

// File: rtl/cmp_adc_dp.sv
module cmp_adc_dp
  import cmp_adc_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  convStrobe_t       strobe,
  input  logic              goBit,
  input  logic              irqFlag,
  output logic              matchHit,
  output logic              enBit,
  output logic [TMR_W-1:0]  timerVal,
  output logic [DATA_W-1:0] regRdata
);
  localparam int NBYTES = TMR_W / DATA_W;

  logic [TMR_W-1:0]  timerQ, timerNext, cmpQ, cmpNext;
  logic [3:0]        modeQ;
  logic [1:0]        clkSelQ;
  logic [2:0]        chanQ;
  logic              enQ;
  logic [DATA_W-1:0] resultQ;
  logic [NBYTES-1:0] tmrByteWr, cmpByteWr;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byteWr
    assign tmrByteWr[b] = regWe && (regAddr == 3'(int'(A_TMR_LO) + b));
    assign cmpByteWr[b] = regWe && (regAddr == 3'(int'(A_CMP_LO) + b));
  end

  always_comb begin
    if (|tmrByteWr) begin
      timerNext = timerQ;
      for (int b = 0; b < NBYTES; b++)
        if (tmrByteWr[b]) timerNext[b*DATA_W +: DATA_W] = regWdata;
    end else if (strobe.clrTimer) begin
      timerNext = '0;
    end else begin
      timerNext = timerQ + 1'b1;
    end
    cmpNext = cmpQ;
    for (int b = 0; b < NBYTES; b++)
      if (cmpByteWr[b]) cmpNext[b*DATA_W +: DATA_W] = regWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ  <= '0;
      cmpQ    <= '0;
      modeQ   <= '0;
      clkSelQ <= '0;
      chanQ   <= '0;
      enQ     <= 1'b0;
    end else begin
      timerQ <= timerNext;
      cmpQ   <= cmpNext;
      if (regWe && regAddr == A_MODE) modeQ <= regWdata[3:0];
      if (regWe && regAddr == A_CTRL) begin
        clkSelQ <= regWdata[7:6];
        chanQ   <= regWdata[5:3];
        enQ     <= regWdata[EN_BIT];
      end
    end
  end

  // result is left uninitialised after reset
  always_ff @(posedge clk) begin
    if (strobe.finishConv) resultQ <= stubResult(chanQ);
  end

  assign matchHit = (modeQ == SPECIAL_MODE) && (timerQ == cmpQ);
  assign enBit    = enQ;
  assign timerVal = timerQ;

  always_comb begin
    case (regAddr)
      A_TMR_LO: regRdata = timerQ[DATA_W-1:0];
      A_TMR_HI: regRdata = timerQ[2*DATA_W-1:DATA_W];
      A_CMP_LO: regRdata = cmpQ[DATA_W-1:0];
      A_CMP_HI: regRdata = cmpQ[2*DATA_W-1:DATA_W];
      A_MODE:   regRdata = {4'b0, modeQ};
      A_CTRL:   regRdata = {clkSelQ, chanQ, goBit, 1'b0, enQ};
      A_RES:    regRdata = resultQ;
      default:  regRdata = {7'b0, irqFlag};
    endcase
  end
endmodule

// File: rtl/cmp_adc_starter.sv
module cmp_adc_starter
  import cmp_adc_pkg::*;
#(
  parameter int CONV_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       cmpEvent,
  output logic       adcIrq
);
  localparam int TMR_W = 2 * DATA_W;

  convStrobe_t      strobe;
  logic             goBit, enBit, matchHit, wrCtrl, wrFlagClr;
  logic [TMR_W-1:0] timerVal;

  assign wrCtrl    = regWe && (regAddr == A_CTRL);
  assign wrFlagClr = regWe && (regAddr == A_FLAG) && regWdata[0];

  cmp_adc_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .matchHit(matchHit), .enBit(enBit),
    .wrCtrl(wrCtrl), .wrGoVal(regWdata[GO_BIT]), .wrFlagClr(wrFlagClr),
    .strobe(strobe), .goBit(goBit), .irqFlag(adcIrq)
  );

  cmp_adc_dp #(.TMR_W(TMR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe), .goBit(goBit), .irqFlag(adcIrq),
    .matchHit(matchHit), .enBit(enBit), .timerVal(timerVal),
    .regRdata(regRdata)
  );

  assign cmpEvent = matchHit;
endmodule

// File: rtl/cmp_adc_chk.sv
module cmp_adc_chk #(
  parameter int CONV_CYCLES = 12
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [2:0]  regAddr,
  input logic [7:0]  regWdata,
  input logic        cmpEvent,
  input logic [15:0] timerVal,
  input logic        goBit,
  input logic        enBit,
  input logic        adcIrq
);
  int busyCnt;
  logic tmrWr, abortWr;

  assign tmrWr   = regWe && (regAddr <= 3'd1);
  assign abortWr = regWe && (regAddr == 3'd5) && !regWdata[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= 0;
    else if (goBit) busyCnt <= busyCnt + 1;
    else busyCnt <= 0;
  end

  a_r3_event_clears_timer: assert property (@(posedge clk) disable iff (!rstN)
    cmpEvent && !tmrWr |=> timerVal == 16'd0);

  a_r2_timer_counts: assert property (@(posedge clk) disable iff (!rstN)
    !cmpEvent && !tmrWr |=> timerVal == 16'($past(timerVal) + 16'd1));

  a_r6_start_needs_prior_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goBit) |-> $past(enBit));

  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    goBit |-> busyCnt < CONV_CYCLES);

  a_r7_finish_sets_irq: assert property (@(posedge clk) disable iff (!rstN)
    goBit && busyCnt == CONV_CYCLES - 1 |=> !goBit && adcIrq);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    goBit && cmpEvent && !abortWr && busyCnt < CONV_CYCLES - 1 |=> goBit);

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    goBit && abortWr && !adcIrq && busyCnt < CONV_CYCLES - 1 |=> !goBit && !adcIrq);
endmodule

bind cmp_adc_starter cmp_adc_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .cmpEvent(cmpEvent), .timerVal(timerVal),
  .goBit(goBit), .enBit(enBit), .adcIrq(adcIrq)
);

// File: tb/cmp_adc_starter_tb.sv
module cmp_adc_starter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic cmpEvent, adcIrq;

  int compared = 0, mismatched = 0;
  string curReq = "R10";

  cmp_adc_starter #(.CONV_CYCLES(N)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cmpEvent(cmpEvent),
    .adcIrq(adcIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [15:0] mTmr = 0, mCmp = 0;
  logic [3:0]  mMode = 0;
  logic [1:0]  mClk = 0;
  logic [2:0]  mChan = 0;
  logic        mEn = 0, mGo = 0, mFlag = 0, mResValid = 0;
  logic [7:0]  mRes = 0;
  int          mCnt = 0;

  function automatic logic modelEvent();
    return (mMode == 4'b1011) && (mTmr == mCmp);
  endfunction

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mTmr[7:0];
      3'd1: return mTmr[15:8];
      3'd2: return mCmp[7:0];
      3'd3: return mCmp[15:8];
      3'd4: return {4'b0, mMode};
      3'd5: return {mClk, mChan, mGo, 1'b0, mEn};
      3'd6: return mRes;
      default: return {7'b0, mFlag};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTmr = 0; mCmp = 0; mMode = 0; mClk = 0; mChan = 0;
      mEn = 0; mGo = 0; mFlag = 0; mCnt = 0;
    end else begin
      logic ev, fin, start, abrt, ctrlWr;
      ev     = modelEvent();
      ctrlWr = regWe && regAddr == 3'd5;
      fin    = mGo && (mCnt == N - 1);
      start  = !mGo && mEn && (ev || (ctrlWr && regWdata[2]));
      abrt   = mGo && !fin && ctrlWr && !regWdata[2];
      if (fin) begin mRes = {mChan, ~mChan, 2'b10}; mResValid = 1; end
      if (fin) mFlag = 1;
      else if (regWe && regAddr == 3'd7 && regWdata[0]) mFlag = 0;
      if (start) begin mGo = 1; mCnt = 0; end
      else if (fin || abrt) begin mGo = 0; mCnt = 0; end
      else if (mGo) mCnt = mCnt + 1;
      if (regWe && regAddr == 3'd0) mTmr[7:0] = regWdata;
      else if (regWe && regAddr == 3'd1) mTmr[15:8] = regWdata;
      else if (ev) mTmr = 0;
      else mTmr = mTmr + 16'd1;
      if (regWe && regAddr == 3'd2) mCmp[7:0] = regWdata;
      if (regWe && regAddr == 3'd3) mCmp[15:8] = regWdata;
      if (regWe && regAddr == 3'd4) mMode = regWdata[3:0];
      if (ctrlWr) begin mClk = regWdata[7:6]; mChan = regWdata[5:3]; mEn = regWdata[0]; end
    end
  end

  task automatic check1(input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check1("cmpEvent", {7'b0, cmpEvent}, {7'b0, modelEvent()});
    check1("adcIrq", {7'b0, adcIrq}, {7'b0, mFlag});
    if (!(regAddr == 3'd6 && !mResValid))
      check1("regRdata", regRdata, modelRead(regAddr));
  endtask

  // one clock with given inputs; compare at the following negedge
  task automatic tick(input logic we, input logic [2:0] a, input logic [7:0] d);
    regWe = we; regAddr = a; regWdata = d;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) tick(1'b0, a, 8'd0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    tick(1'b1, a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(3, 3'd5);
    rstN = 1'b1;
    // R10: reset values of every register
    curReq = "R10";
    for (int a = 0; a < 8; a++) if (a != 6) idle(1, 3'(a));
    // R2: free counting
    curReq = "R2";
    idle(6, 3'd0);
    // R1 R5: events with enable clear reset timer only
    curReq = "R5";
    wr(3'd2, 8'd20); wr(3'd4, 8'hFB); wr(3'd0, 8'd0);
    for (int i = 0; i < 50; i++) idle(1, 3'(i % 2 == 0 ? 5 : 0));
    // R1: wrong mode produces no event
    curReq = "R1";
    wr(3'd4, 8'h0A); wr(3'd0, 8'd15); idle(10, 3'd0);
    wr(3'd4, 8'h0B); wr(3'd0, 8'd0);
    // R6: enable and start together do not start
    curReq = "R6";
    wr(3'd5, 8'h05); idle(1, 3'd5);
    wr(3'd5, 8'h00);
    // R4 R7: events start conversions with channel 3
    curReq = "R7";
    wr(3'd5, 8'h59); wr(3'd0, 8'd0);
    idle(70, 3'd5); idle(2, 3'd6);
    // R11: clear flag
    curReq = "R11";
    wr(3'd7, 8'h01); idle(2, 3'd7);
    // R8: event period shorter than a conversion
    curReq = "R8";
    wr(3'd2, 8'd5); wr(3'd0, 8'd0);
    idle(40, 3'd5);
    // R9: software start then abort with no events
    curReq = "R9";
    wr(3'd4, 8'd0); wr(3'd7, 8'h01);
    wr(3'd5, 8'h2D); idle(3, 3'd5);
    wr(3'd5, 8'h29); idle(2, 3'd7); idle(2, 3'd6); idle(2, 3'd5);
    // R4: event coincides with control write that leaves start at 0
    curReq = "R4";
    wr(3'd2, 8'd8); wr(3'd4, 8'h0B); wr(3'd0, 8'd0);
    for (int i = 0; i < 100; i++) begin
      if (modelEvent() && !mGo) begin wr(3'd5, 8'h19); break; end
      idle(1, 3'd5);
    end
    idle(3, 3'd5);
    // R6 R5: event coincides with write enabling and starting at once
    curReq = "R6";
    for (int i = 0; i < 60 && mGo; i++) idle(1, 3'd5);
    wr(3'd5, 8'h00);
    for (int i = 0; i < 100; i++) begin
      if (modelEvent()) begin wr(3'd5, 8'h05); break; end
      idle(1, 3'd0);
    end
    idle(3, 3'd5); idle(2, 3'd0);
    // R11: completion in the same cycle as a flag clear
    curReq = "R11";
    for (int i = 0; i < 100; i++) begin
      if (mGo && mCnt == N - 1) begin wr(3'd7, 8'h01); break; end
      idle(1, 3'd7);
    end
    idle(3, 3'd7);
    // R2: timer byte write wins over event clear
    curReq = "R2";
    for (int i = 0; i < 100; i++) begin
      if (modelEvent()) begin wr(3'd0, 8'h40); break; end
      idle(1, 3'd0);
    end
    idle(4, 3'd0);
    wr(3'd1, 8'h12); idle(2, 3'd1);
    // R2: wrap at 16 bits
    wr(3'd4, 8'd0); wr(3'd1, 8'hFF); wr(3'd0, 8'hFD);
    idle(5, 3'd1); idle(2, 3'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule